// File: doc/BRIEF.md
# Video Stream Color Match Sampler

This block sits inline in a pixel stream and forwards every beat untouched in the same cycle, so the video path gains no register stage. While pixels flow past, it keeps the column and row of the current beat. It checks the chroma of pixels that lie on a coarse grid (every eighth column of every eighth row) against a programmable window. For each pixel that passes, it writes the pixel's coordinates through a memory write port, so that a later clustering stage can read a compact list of hit positions instead of the whole frame.

Configuration inputs set the two chroma windows, turn on highlighting, and give the highlight color. When highlighting is on, every matched pixel leaves the block replaced by that color, which shows the operator what the filter selects. At the last beat of a frame the block latches how many coordinates it stored and gives a one-cycle done pulse. If the memory fills within a frame, the block stops writing and sets a saturation flag for that frame.

Top module: `vid_chroma_sampler`

## Requirements
- R1: m_tvalid, m_tuser and m_tlast equal s_tvalid, s_tuser and s_tlast in the same cycle; s_tready equals m_tready; m_tdata equals s_tdata whenever the pixel is not painted.
- R2: A beat with s_tuser high is at column 0, row 0. After a handshaken beat with s_tlast high, the next beat is at column 0 of the following row; otherwise the column advances by one. Positions change only on a handshake (s_tvalid and m_tready both high).
- R3: With cfg_paint_en high, a matched pixel leaves on m_tdata as cfg_paint_color in the same cycle. No other pixel is altered.
- R4: Only pixels whose column and row are both multiples of 2^GRID_LOG2 (8 by default) can match.
- R5: Pixel layout is Y in s_tdata[7:0], Cb in [15:8] and Cr in [23:16]. A pixel matches when cfg_cb_lo <= Cb <= cfg_cb_hi and cfg_cr_lo <= Cr <= cfg_cr_hi, with both bounds inclusive. Y has no effect.
- R6: On the handshake cycle of a matched pixel, mem_we is high and mem_wdata = {row, column}, with the row in the upper ROW_W bits. mem_addr is 0 for the first write of a frame and rises by one for each later write.
- R7: One cycle after the handshake of the beat with s_tlast high on row ROWS-1, stat_frame_done is high for exactly one cycle and stat_match_count holds the number of writes made in that frame.
- R8: Once DEPTH writes have been made in a frame, further matches do not raise mem_we. That frame reports stat_match_count = DEPTH and stat_saturated = 1. A frame without overflow reports stat_saturated = 0.
- R9: While m_tready is low, mem_we stays low and position and write count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 24 | Input pixel {Cr, Cb, Y} |
| s_tvalid | input | 1 | Input beat valid |
| s_tuser | input | 1 | Input start of frame |
| s_tlast | input | 1 | Input end of line |
| s_tready | output | 1 | Ready back to the source |
| m_tdata | output | 24 | Output pixel, possibly painted |
| m_tvalid | output | 1 | Output beat valid |
| m_tuser | output | 1 | Output start of frame |
| m_tlast | output | 1 | Output end of line |
| m_tready | input | 1 | Ready from the sink |
| cfg_cb_lo | input | 8 | Cb lower bound |
| cfg_cb_hi | input | 8 | Cb upper bound |
| cfg_cr_lo | input | 8 | Cr lower bound |
| cfg_cr_hi | input | 8 | Cr upper bound |
| cfg_paint_en | input | 1 | Highlight matched pixels |
| cfg_paint_color | input | 24 | Highlight value |
| mem_we | output | 1 | Match memory write enable |
| mem_addr | output | AW | Match memory write address |
| mem_wdata | output | ROW_W+COL_W | {row, column} of the match |
| stat_match_count | output | CW | Writes made in the last finished frame |
| stat_frame_done | output | 1 | One-cycle end-of-frame pulse |
| stat_saturated | output | 1 | Last finished frame overflowed the memory |

## Verification
A wrong column or row count shows at the ports as soon as the next grid pixel arrives. The write then appears at the wrong beat, or carries coordinates that do not match that beat, and a highlighted pixel lands off the grid. A write pointer that is not cleared at start of frame shows on the first write of the new frame as a nonzero address, and at frame end as a wrong count. A stall that lets state advance shows on the beat after the stall as a shifted coordinate or a duplicate write.

// File: rtl/vid_chroma_sampler.sv
module vid_chroma_sampler #(
  parameter int COL_W     = 11,
  parameter int ROW_W     = 11,
  parameter int GRID_LOG2 = 3,
  parameter int ROWS      = 1080,
  parameter int DEPTH     = 64800,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [23:0]            s_tdata,
  input  logic                   s_tvalid,
  input  logic                   s_tuser,
  input  logic                   s_tlast,
  output logic                   s_tready,
  output logic [23:0]            m_tdata,
  output logic                   m_tvalid,
  output logic                   m_tuser,
  output logic                   m_tlast,
  input  logic                   m_tready,
  input  logic [7:0]             cfg_cb_lo,
  input  logic [7:0]             cfg_cb_hi,
  input  logic [7:0]             cfg_cr_lo,
  input  logic [7:0]             cfg_cr_hi,
  input  logic                   cfg_paint_en,
  input  logic [23:0]            cfg_paint_color,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [ROW_W+COL_W-1:0] mem_wdata,
  output logic [CW-1:0]          stat_match_count,
  output logic                   stat_frame_done,
  output logic                   stat_saturated
);

  logic [COL_W-1:0] col_q, col_cur;
  logic [ROW_W-1:0] row_q, row_cur;
  logic [CW-1:0]    ptr_q, ptr_cur;
  logic             sat_q, sat_cur;
  logic [7:0]       cb, cr;
  logic             hs, in_win, on_grid, hit, full, overflow, frame_end;

  assign hs      = s_tvalid & m_tready;
  assign col_cur = s_tuser ? '0 : col_q;
  assign row_cur = s_tuser ? '0 : row_q;
  assign ptr_cur = s_tuser ? '0 : ptr_q;
  assign sat_cur = s_tuser ? 1'b0 : sat_q;

  assign cb      = s_tdata[15:8];
  assign cr      = s_tdata[23:16];
  assign in_win  = (cb >= cfg_cb_lo) && (cb <= cfg_cb_hi) &&
                   (cr >= cfg_cr_lo) && (cr <= cfg_cr_hi);
  assign on_grid = (col_cur[GRID_LOG2-1:0] == '0) && (row_cur[GRID_LOG2-1:0] == '0);
  assign hit     = s_tvalid & on_grid & in_win;

  assign full      = (ptr_cur == CW'(DEPTH));
  assign overflow  = hit & m_tready & full;
  assign frame_end = hs & s_tlast & (row_cur == ROW_W'(ROWS - 1));

  assign s_tready = m_tready;
  assign m_tvalid = s_tvalid;
  assign m_tuser  = s_tuser;
  assign m_tlast  = s_tlast;
  assign m_tdata  = (cfg_paint_en & hit) ? cfg_paint_color : s_tdata;

  assign mem_we    = hit & m_tready & ~full;
  assign mem_addr  = AW'(ptr_cur);
  assign mem_wdata = {row_cur, col_cur};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q            <= '0;
      row_q            <= '0;
      ptr_q            <= '0;
      sat_q            <= 1'b0;
      stat_match_count <= '0;
      stat_frame_done  <= 1'b0;
      stat_saturated   <= 1'b0;
    end else begin
      stat_frame_done <= frame_end;
      if (hs) begin
        if (s_tlast) begin
          col_q <= '0;
          row_q <= row_cur + 1'b1;
        end else begin
          col_q <= col_cur + 1'b1;
          row_q <= row_cur;
        end
        ptr_q <= ptr_cur + CW'(mem_we);
        sat_q <= sat_cur | overflow;
      end
      if (frame_end) begin
        stat_match_count <= ptr_cur + CW'(mem_we);
        stat_saturated   <= sat_cur | overflow;
      end
    end
  end

endmodule

module vid_chroma_sampler_chk #(
  parameter int COL_W     = 11,
  parameter int ROW_W     = 11,
  parameter int GRID_LOG2 = 3,
  parameter int DEPTH     = 64800,
  parameter int CW        = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [23:0]            s_tdata,
  input logic                   s_tvalid,
  input logic                   m_tready,
  input logic [23:0]            m_tdata,
  input logic                   cfg_paint_en,
  input logic                   mem_we,
  input logic [ROW_W+COL_W-1:0] mem_wdata,
  input logic [CW-1:0]          stat_match_count,
  input logic                   stat_frame_done
);

  a_r9_no_write_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (s_tvalid && m_tready));

  a_r4_write_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[GRID_LOG2-1:0] == '0 &&
                mem_wdata[COL_W+GRID_LOG2-1:COL_W] == '0));

  a_r3_paint_only_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tdata != s_tdata) |-> (cfg_paint_en && s_tvalid));

  a_r7_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stat_frame_done |=> !stat_frame_done);

  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    stat_match_count <= CW'(DEPTH));

endmodule

bind vid_chroma_sampler vid_chroma_sampler_chk #(
  .COL_W(COL_W), .ROW_W(ROW_W), .GRID_LOG2(GRID_LOG2), .DEPTH(DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
  .m_tready(m_tready), .m_tdata(m_tdata), .cfg_paint_en(cfg_paint_en),
  .mem_we(mem_we), .mem_wdata(mem_wdata), .stat_match_count(stat_match_count),
  .stat_frame_done(stat_frame_done)
);

// File: tb/sim_vid_chroma_sampler.sv
module sim_vid_chroma_sampler;
  localparam int COLS  = 16;
  localparam int ROWS  = 16;
  localparam int DEPTH = 3;
  localparam int AW    = 2;
  localparam int CW    = 2;

  logic clk = 0, rst_n = 0;
  logic [23:0] s_tdata = '0, m_tdata;
  logic s_tvalid = 0, s_tuser = 0, s_tlast = 0, s_tready;
  logic m_tvalid, m_tuser, m_tlast, m_tready = 1;
  logic [7:0] cb_lo = 8'h40, cb_hi = 8'h60, cr_lo = 8'hA0, cr_hi = 8'hB0;
  logic paint_en = 0;
  logic [23:0] paint_color = 24'hFF00FF;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [21:0] mem_wdata;
  logic [CW-1:0] stat_match_count;
  logic stat_frame_done, stat_saturated;

  int nchk = 0, nfail = 0;
  int exp_ptr = 0;
  bit exp_sat = 0;

  always #5 clk = ~clk;

  vid_chroma_sampler #(.ROWS(ROWS), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tuser(s_tuser), .s_tlast(s_tlast), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tuser(m_tuser), .m_tlast(m_tlast),
    .m_tready(m_tready), .cfg_cb_lo(cb_lo), .cfg_cb_hi(cb_hi), .cfg_cr_lo(cr_lo),
    .cfg_cr_hi(cr_hi), .cfg_paint_en(paint_en), .cfg_paint_color(paint_color),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .stat_match_count(stat_match_count), .stat_frame_done(stat_frame_done),
    .stat_saturated(stat_saturated));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pixel {Cr, Cb, Y}; Y varies so that R5's "Y has no effect" is exercised
  function automatic logic [23:0] pix(int mode, int r, int c);
    logic [7:0] y;
    y = 8'(r * 16 + c);
    case (mode)
      0: return {8'hA8, 8'h50, y};
      1: return {8'h20, 8'h50, y};
      default: begin
        if (r == 0 && c == 8)      return {8'hA8, 8'h3F, y};
        else if (r == 8 && c == 8) return {8'hB1, 8'h50, y};
        else if (r == 8 && c == 0) return {8'hA0, 8'h60, y};
        else                       return {8'hB0, 8'h40, y};
      end
    endcase
  endfunction

  task automatic send_pix(int mode, int r, int c, bit stall, bit bubble);
    logic [23:0] d;
    bit hit, we;
    d = pix(mode, r, c);
    if (bubble) begin
      s_tvalid = 0; m_tready = 1; s_tdata = d;
      #1;
      chk("R1 bubble valid", m_tvalid, 0);
      chk("R9 bubble no write", mem_we, 0);
      @(negedge clk);
    end
    s_tdata = d; s_tuser = (r == 0 && c == 0); s_tlast = (c == COLS - 1);
    if (s_tuser) begin exp_ptr = 0; exp_sat = 0; end
    hit = (r % 8 == 0) && (c % 8 == 0) &&
          d[15:8] >= cb_lo && d[15:8] <= cb_hi && d[23:16] >= cr_lo && d[23:16] <= cr_hi;
    if (stall) begin
      for (int k = 0; k < 2; k++) begin
        s_tvalid = 1; m_tready = 0;
        #1;
        chk("R1 ready forwarded", s_tready, 0);
        chk("R9 stalled no write", mem_we, 0);
        @(negedge clk);
      end
    end
    s_tvalid = 1; m_tready = 1;
    #1;
    we = hit && exp_ptr < DEPTH;
    chk("R6/R4/R8 write enable", mem_we, we);
    if (we) begin
      chk("R6 address", mem_addr, exp_ptr);
      chk("R6/R2 coordinates", mem_wdata, {11'(r), 11'(c)});
    end
    chk("R3/R1 data", m_tdata, (paint_en && hit) ? paint_color : d);
    chk("R1 sideband", {m_tvalid, m_tuser, m_tlast}, {1'b1, s_tuser, s_tlast});
    @(negedge clk);
    if (we) exp_ptr++;
    if (hit && !we) exp_sat = 1;
    s_tvalid = 0; s_tuser = 0; s_tlast = 0;
  endtask

  task automatic send_frame(int mode, int nrows, bit stalls);
    for (int r = 0; r < nrows; r++)
      for (int c = 0; c < COLS; c++)
        send_pix(mode, r, c, stalls && c == 8, stalls && c == 4);
    if (nrows == ROWS) begin
      chk("R7 done pulse", stat_frame_done, 1);
      chk("R7/R8 frame count", stat_match_count, exp_ptr);
      chk("R8 saturation flag", stat_saturated, exp_sat);
      @(negedge clk);
      chk("R7 pulse one cycle", stat_frame_done, 0);
    end
  endtask

  task automatic t_reset;
    #1;
    chk("R7 reset done", stat_frame_done, 0);
    chk("R7 reset count", stat_match_count, 0);
    chk("R8 reset sat", stat_saturated, 0);
    chk("R6 reset we", mem_we, 0);
  endtask

  task automatic t_window;      // R5 inclusive bounds, R3 paint, R4 grid
    paint_en = 1;
    send_frame(2, ROWS, 0);
    chk("R5 two hits", stat_match_count, 2);
  endtask

  task automatic t_nomatch;
    paint_en = 1;
    send_frame(1, ROWS, 0);
    chk("R5 no hits", stat_match_count, 0);
  endtask

  task automatic t_saturate;    // R8
    paint_en = 0;
    send_frame(0, ROWS, 0);
    chk("R8 count at depth", stat_match_count, DEPTH);
    chk("R8 saturated set", stat_saturated, 1);
  endtask

  task automatic t_stall;       // R9, R2
    paint_en = 1;
    send_frame(2, ROWS, 1);
    chk("R9 count after stalls", stat_match_count, 2);
    chk("R8 saturated cleared", stat_saturated, 0);
  endtask

  task automatic t_restart;     // R2, R6: abort a frame, restart at tuser
    paint_en = 0;
    send_frame(0, 9, 0);
    send_frame(2, ROWS, 0);
    chk("R2 restart count", stat_match_count, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_window;
    t_nomatch;
    t_saturate;
    t_stall;
    t_restart;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule